// File: doc/BRIEF.md
# Cycle-Partitioned Event Timestamp Framer

This block turns front-end triggers into time-tagged data words for a downstream buffer. It keeps a fine-time counter that advances once per clock tick, where one tick is 10 ns at the intended 100 MHz clock. A once-per-second cycle strobe restarts that counter, so every event stamp is a time offset from the start of its own acquisition cycle. Each trigger captures the counter value at the moment its rising edge is seen. That value leaves the block as an event word.

Every cycle strobe also creates a cycle-marker word. The marker carries an 8-bit cycle number, and it goes out ahead of any event that is still waiting, so the output stream is already cut into cycles. The output uses a valid/ready handshake. Storage is kept small: one marker and one event can wait while the consumer stalls. Anything beyond that is discarded and recorded in a sticky overflow flag.

A host interrupt line pulses when a new cycle begins. It also pulses when the buffer occupancy reported to the block climbs to a programmable threshold.

Top module: `timestamp_framer`

## Requirements
- R1: While reset is asserted and right after it is released, valid_o, irq_o and overflow_o are 0, and the cycle number is 0.
- R2: pps_i and trig_i each pass through a two-flop synchronizer, and only a 0-to-1 transition acts. A level first sampled high at clock edge k takes effect at edge k+2. An input held high for many cycles acts once.
- R3: The edge that registers a cycle-strobe rising edge is time 0 of the new cycle. An event registered k edges later is stamped k. A trigger registered at the same edge as the strobe is stamped 0.
- R4: Words are TS_W+1 bits wide, and the top bit is the tag: 1 means cycle marker and 0 means event. An event word carries its stamp in bits [TS_W-1:0]. A marker carries the cycle number in bits [CYC_W-1:0], and all its other payload bits are 0.
- R5: The first marker after reset carries cycle number 0. Each later strobe carries a number one higher, and the count wraps from 255 to 0.
- R6: When a marker and an event are both waiting, the marker is presented first, even if the event was presented earlier.
- R7: A word is consumed on a clock edge where valid_o and ready_i are both 1. valid_o stays high while ready_i is low.
- R8: At most one marker and one event wait at a time. A trigger that arrives while the event slot is full and not being emptied on that edge is dropped. The same holds for a strobe arriving while the marker slot is full. Either kind of drop sets overflow_o, which stays set until reset.
- R9: irq_o pulses high for one cycle in the same cycle in which the marker of a new strobe first becomes visible.
- R10: irq_o pulses high for one cycle after the first edge at which occ_i >= occ_thresh_i holds, following an edge where it did not hold. It does not pulse again while the condition stays true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_i | input | 1 | Cycle strobe, asynchronous |
| trig_i | input | 1 | Front-end trigger, asynchronous |
| occ_i | input | OCC_W | Downstream buffer occupancy |
| occ_thresh_i | input | OCC_W | Occupancy interrupt threshold |
| word_o | output | TS_W+1 | Tagged output word |
| valid_o | output | 1 | word_o holds a word |
| ready_i | input | 1 | Consumer accepts word_o |
| irq_o | output | 1 | Host interrupt pulse |
| overflow_o | output | 1 | Sticky dropped-word flag |

## Verification
The assertions check the following on every cycle:
- A strobe edge is followed at once by a visible marker and an interrupt.
- A stalled word keeps valid_o high.
- A trigger that meets a full event slot always raises overflow_o, and overflow_o never falls.
- A detected edge lasts only one cycle.
- A trigger that coincides with a strobe is stored with stamp 0.

The bench scenarios cover the rest:
- the exact stamp values over a range of trigger-to-strobe gaps;
- marker-before-event ordering under back-pressure;
- which word is lost on overflow;
- cycle-number wrap after 256 strobes;
- the edge-only behaviour of the occupancy interrupt.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  // tag carried in the top bit of every output word
  typedef enum logic {
    TAG_EVENT  = 1'b0,
    TAG_MARKER = 1'b1
  } word_tag_e;

  localparam int unsigned DEF_TS_W   = 27;
  localparam int unsigned DEF_CYC_W  = 8;
  localparam int unsigned DEF_OCC_W  = 17;
  localparam int unsigned DEF_STAGES = 2;
endpackage

// File: rtl/tsf_edge_sync.sv
module tsf_edge_sync #(
  parameter int unsigned STAGES = tsf_pkg::DEF_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;

  AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R2
endmodule

// File: rtl/tsf_timebase.sv
module tsf_timebase #(
  parameter int unsigned TS_W  = tsf_pkg::DEF_TS_W,
  parameter int unsigned CYC_W = tsf_pkg::DEF_CYC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_rise_i,
  output logic [TS_W-1:0]  stamp_o,
  output logic [CYC_W-1:0] cyc_num_o
);
  logic [TS_W-1:0]  cnt_q;
  logic [CYC_W-1:0] cyc_q;

  // the strobe edge itself is time 0, so the following edge sees 1
  function automatic logic [TS_W-1:0] next_count(input logic restart,
                                                 input logic [TS_W-1:0] cur);
    logic [TS_W-1:0] one;
    one = {{(TS_W-1){1'b0}}, 1'b1};
    return restart ? one : cur + one;
  endfunction

  function automatic logic [CYC_W-1:0] next_cycle(input logic [CYC_W-1:0] cur);
    return cur + {{(CYC_W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cyc_q <= '0;
    end else begin
      cnt_q <= next_count(pps_rise_i, cnt_q);
      if (pps_rise_i) cyc_q <= next_cycle(cyc_q);
    end
  end

  assign stamp_o   = pps_rise_i ? '0 : cnt_q;
  assign cyc_num_o = cyc_q;
endmodule

// File: rtl/tsf_slot_arb.sv
module tsf_slot_arb
  import tsf_pkg::*;
#(
  parameter int unsigned TS_W  = DEF_TS_W,
  parameter int unsigned CYC_W = DEF_CYC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_rise_i,
  input  logic             trig_rise_i,
  input  logic [TS_W-1:0]  stamp_i,
  input  logic [CYC_W-1:0] cyc_num_i,
  input  logic             ready_i,
  output logic [TS_W:0]    word_o,
  output logic             valid_o,
  output logic             mk_busy_o,
  output logic             ev_busy_o,
  output logic             ovf_o
);
  localparam int unsigned WORD_W = TS_W + 1;

  logic             mk_vld_q, ev_vld_q, ovf_q;
  logic [CYC_W-1:0] mk_num_q;
  logic [TS_W-1:0]  ev_ts_q;

  logic fire, mk_take, ev_take, mk_load, ev_load, mk_drop, ev_drop;

  function automatic logic [WORD_W-1:0] pack_marker(input logic [CYC_W-1:0] n);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1]  = TAG_MARKER;
    w[CYC_W-1:0] = n;
    return w;
  endfunction

  function automatic logic [WORD_W-1:0] pack_event(input logic [TS_W-1:0] ts);
    return {TAG_EVENT, ts};
  endfunction

  assign fire    = valid_o & ready_i;
  assign mk_take = fire & mk_vld_q;
  assign ev_take = fire & ~mk_vld_q;
  assign mk_load = pps_rise_i  & (~mk_vld_q | mk_take);
  assign ev_load = trig_rise_i & (~ev_vld_q | ev_take);
  assign mk_drop = pps_rise_i  & ~mk_load;
  assign ev_drop = trig_rise_i & ~ev_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk_vld_q <= 1'b0;
      mk_num_q <= '0;
    end else if (mk_load) begin
      mk_vld_q <= 1'b1;
      mk_num_q <= cyc_num_i;
    end else if (mk_take) begin
      mk_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_vld_q <= 1'b0;
      ev_ts_q  <= '0;
    end else if (ev_load) begin
      ev_vld_q <= 1'b1;
      ev_ts_q  <= stamp_i;
    end else if (ev_take) begin
      ev_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_q | mk_drop | ev_drop;
  end

  assign valid_o   = mk_vld_q | ev_vld_q;
  assign word_o    = mk_vld_q ? pack_marker(mk_num_q) : pack_event(ev_ts_q);
  assign mk_busy_o = mk_vld_q;
  assign ev_busy_o = ev_vld_q;
  assign ovf_o     = ovf_q;

  AST_EVENT_STAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load && pps_rise_i) |=> (ev_vld_q && ev_ts_q == '0)); // R3
endmodule

// File: rtl/tsf_irq_gen.sv
module tsf_irq_gen #(
  parameter int unsigned OCC_W = tsf_pkg::DEF_OCC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_rise_i,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [OCC_W-1:0] thresh_i,
  output logic             irq_o
);
  logic above, above_q, irq_q;

  function automatic logic reached(input logic [OCC_W-1:0] occ,
                                   input logic [OCC_W-1:0] thr);
    return occ >= thr;
  endfunction

  assign above = reached(occ_i, thresh_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      above_q <= above;
      irq_q   <= pps_rise_i | (above & ~above_q);
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/timestamp_framer.sv
module timestamp_framer #(
  parameter int unsigned TS_W   = tsf_pkg::DEF_TS_W,
  parameter int unsigned CYC_W  = tsf_pkg::DEF_CYC_W,
  parameter int unsigned OCC_W  = tsf_pkg::DEF_OCC_W,
  parameter int unsigned STAGES = tsf_pkg::DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pps_i,
  input  logic             trig_i,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [OCC_W-1:0] occ_thresh_i,
  output logic [TS_W:0]    word_o,
  output logic             valid_o,
  input  logic             ready_i,
  output logic             irq_o,
  output logic             overflow_o
);
  localparam int unsigned WORD_W = TS_W + 1;

  // internal events brought out as named wires
  logic             pps_rise, trig_rise;
  logic [TS_W-1:0]  stamp;
  logic [CYC_W-1:0] cyc_num;
  logic             mk_busy, ev_busy;

  tsf_edge_sync #(.STAGES(STAGES)) u_pps_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pps_i), .rise_o(pps_rise));

  tsf_edge_sync #(.STAGES(STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .async_i(trig_i), .rise_o(trig_rise));

  tsf_timebase #(.TS_W(TS_W), .CYC_W(CYC_W)) u_timebase (
    .clk(clk), .rst_n(rst_n), .pps_rise_i(pps_rise),
    .stamp_o(stamp), .cyc_num_o(cyc_num));

  tsf_slot_arb #(.TS_W(TS_W), .CYC_W(CYC_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .pps_rise_i(pps_rise), .trig_rise_i(trig_rise),
    .stamp_i(stamp), .cyc_num_i(cyc_num), .ready_i(ready_i),
    .word_o(word_o), .valid_o(valid_o), .mk_busy_o(mk_busy),
    .ev_busy_o(ev_busy), .ovf_o(overflow_o));

  tsf_irq_gen #(.OCC_W(OCC_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .pps_rise_i(pps_rise), .occ_i(occ_i),
    .thresh_i(occ_thresh_i), .irq_o(irq_o));

  AST_MARKER_ON_PPS: assert property (@(posedge clk) disable iff (!rst_n)
    pps_rise |=> (valid_o && word_o[WORD_W-1])); // R6
  AST_IRQ_ON_PPS: assert property (@(posedge clk) disable iff (!rst_n)
    pps_rise |=> irq_o); // R9
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o); // R7
  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_rise && ev_busy && !(valid_o && ready_i && !mk_busy)) |=> overflow_o); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o); // R8
endmodule

// File: tb/tb_timestamp_framer.sv
module tb_timestamp_framer;
  localparam int TS_W = 27;
  localparam int CYC_W = 8;
  localparam int OCC_W = 17;
  localparam int WORD_W = TS_W + 1;
  localparam int NVEC = 7;
  // {strobe-to-trigger gap in edges, expected stamp}
  localparam int VEC [NVEC][2] = '{'{0,0}, '{1,1}, '{2,2}, '{5,5},
                                   '{13,13}, '{40,40}, '{100,100}};

  logic clk = 0, rst_n = 0, pps_i = 0, trig_i = 0, ready_i = 1;
  logic [OCC_W-1:0] occ_i = '0, occ_thresh_i = 17'd100;
  logic [WORD_W-1:0] word_o;
  logic valid_o, irq_o, overflow_o;

  int total = 0, bad = 0, irq_n = 0, cap_n = 0, cyc_exp = 0;
  logic [WORD_W-1:0] cap [16];
  bit finished = 0;

  timestamp_framer dut (.clk(clk), .rst_n(rst_n), .pps_i(pps_i), .trig_i(trig_i),
    .occ_i(occ_i), .occ_thresh_i(occ_thresh_i), .word_o(word_o), .valid_o(valid_o),
    .ready_i(ready_i), .irq_o(irq_o), .overflow_o(overflow_o));

  always #10 clk = ~clk;

  function automatic logic [WORD_W-1:0] mk_word(int n);
    return {1'b1, {(WORD_W-1-CYC_W){1'b0}}, 8'(n % 256)};
  endfunction
  function automatic logic [WORD_W-1:0] ev_word(int s);
    return {1'b0, 27'(s)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // records the word consumed at the coming edge, then steps to the next negedge
  task automatic tick();
    if (valid_o && ready_i && cap_n < 16) begin cap[cap_n] = word_o; cap_n++; end
    if (irq_o) irq_n++;
    @(negedge clk);
  endtask

  task automatic clear();
    cap_n = 0; irq_n = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) tick();
    chk("R1 valid in reset", 32'(valid_o), 0);
    chk("R1 irq in reset", 32'(irq_o), 0);
    rst_n = 1;
    tick();
    chk("R1 valid after reset", 32'(valid_o), 0);
    chk("R1 overflow after reset", 32'(overflow_o), 0);

    // R2 latency and R9 irq timing, R5 first number
    clear();
    pps_i = 1; tick(); pps_i = 0;
    chk("R2 no effect after edge k", 32'(valid_o), 0);
    tick();
    chk("R2 no effect after edge k+1", 32'(valid_o), 0);
    tick();
    chk("R2 marker after edge k+2", 32'(valid_o), 1);
    chk("R9 irq with marker", 32'(irq_o), 1);
    tick();
    chk("R5 first cycle number", 32'(cap[0]), 32'(mk_word(0)));
    cyc_exp = 1;
    repeat (3) tick();

    // vector table: stamps versus gap, R3 R4 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      clear();
      pps_i = 1;
      if (VEC[i][0] == 0) trig_i = 1;
      tick(); pps_i = 0; trig_i = 0;
      if (VEC[i][0] > 0) begin
        repeat (VEC[i][0] - 1) tick();
        trig_i = 1; tick(); trig_i = 0;
      end
      repeat (6) tick();
      chk("R6 word count", 32'(cap_n), 2);
      chk("R4 R5 marker word first", 32'(cap[0]), 32'(mk_word(cyc_exp)));
      chk("R3 event stamp", 32'(cap[1]), 32'(ev_word(VEC[i][1])));
      chk("R9 one irq per strobe", 32'(irq_n), 1);
      cyc_exp++;
    end

    // R2 held-high trigger acts once
    clear();
    pps_i = 1; tick(); pps_i = 0; tick();
    trig_i = 1; repeat (12) tick(); trig_i = 0;
    repeat (4) tick();
    chk("R2 held trigger word count", 32'(cap_n), 2);
    chk("R2 held trigger stamp", 32'(cap[1]), 32'(ev_word(2)));
    cyc_exp++;

    // R6 marker pre-empts a stalled event
    ready_i = 0; clear();
    trig_i = 1; tick(); trig_i = 0; tick(); tick();
    chk("R7 event waiting valid", 32'(valid_o), 1);
    chk("R6 event shown", 32'(word_o[WORD_W-1]), 0);
    pps_i = 1; tick(); pps_i = 0; tick(); tick();
    chk("R6 marker overtakes", 32'(word_o), 32'(mk_word(cyc_exp)));
    repeat (3) tick();
    chk("R7 valid held", 32'(valid_o), 1);
    ready_i = 1; clear();
    repeat (4) tick();
    chk("R6 drain count", 32'(cap_n), 2);
    chk("R6 drain order", 32'(cap[0]), 32'(mk_word(cyc_exp)));
    chk("R8 no overflow yet", 32'(overflow_o), 0);
    cyc_exp++;

    // R8 second trigger dropped
    ready_i = 0; clear();
    pps_i = 1; tick(); pps_i = 0; repeat (2) tick();
    trig_i = 1; tick(); trig_i = 0; tick();
    trig_i = 1; tick(); trig_i = 0; repeat (3) tick();
    chk("R8 overflow set", 32'(overflow_o), 1);
    ready_i = 1; clear();
    repeat (5) tick();
    chk("R8 kept words", 32'(cap_n), 2);
    chk("R8 kept marker", 32'(cap[0]), 32'(mk_word(cyc_exp)));
    chk("R8 kept first event", 32'(cap[1]), 32'(ev_word(3)));
    chk("R8 overflow sticky", 32'(overflow_o), 1);
    cyc_exp++;

    // R10 occupancy crossing
    occ_thresh_i = 17'd10; occ_i = 17'd5; tick(); tick();
    occ_i = 17'd10; tick();
    chk("R10 irq on reach", 32'(irq_o), 1);
    tick();
    chk("R10 single pulse", 32'(irq_o), 0);
    occ_i = 17'd11; tick(); tick();
    chk("R10 no repeat while above", 32'(irq_o), 0);
    occ_i = 17'd3; tick();
    occ_i = 17'd12; tick();
    chk("R10 irq on second reach", 32'(irq_o), 1);
    occ_thresh_i = 17'd100; occ_i = '0; tick();

    // R5 wrap of the cycle number
    for (int n = 0; n < 258; n++) begin
      clear();
      pps_i = 1; tick(); pps_i = 0; repeat (3) tick();
      chk("R5 cycle number sequence", 32'(cap[0]), 32'(mk_word(cyc_exp)));
      cyc_exp++;
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule